// File: doc/BRIEF.md
# Process-ID Ownership Trace Unit

This block watches software writes to an 8-bit process-ID register and turns them into ownership trace messages, so a host tool can tell which operating-system task is running at any time. Each accepted message carries the process-ID value and a one-bit kind code. The kind code tells a message caused by a register write apart from a periodic refresh.

The unit always tracks the latest process-ID value. When periodic refresh is on, it counts a pulse that the trace system raises for every message it sends, from any source. After 256 such pulses it re-sends the current process ID, so a late-attaching host still learns the active task. The message leaves through a valid/acknowledge pair toward a shared message arbiter. At most one message waits at a time, and a newer process-ID write replaces the waiting value.

Top module: `pid_own_trace`

## Requirements
- R1: After reset `msg_valid`, `msg_pid` and `msg_kind` are all 0.
- R2: With `trace_en` high, a cycle with `pid_we` high makes `msg_valid` 1 on the next cycle, with `msg_pid` equal to the written byte and `msg_kind` 0 (write code).
- R3: While `msg_valid` is 1 and `msg_ack` is 0, `msg_valid`, `msg_pid` and `msg_kind` hold unless a new write arrives. After an acknowledged cycle with no new event, `msg_valid` is 0 on the next cycle.
- R4: With `trace_en` low, no message is raised. A waiting message is withdrawn on the cycle after `trace_en` falls. Writes made while it is low still update the tracked process ID.
- R5: A write that arrives while a message is waiting replaces its value with the new byte and sets the write code.
- R6: With `trace_en` and `period_en` high and no message waiting, the 256th `sent_pulse` since the pulse count was last cleared raises a message on the next cycle. That message has `msg_kind` 1 (periodic code) and carries the most recent process ID.
- R7: The pulse count is cleared when a message is acknowledged and when a periodic refresh fires. It is held at zero while either enable is low.
- R8: With `period_en` low, no periodic message is ever raised.
- R9: A periodic refresh that falls due while a message is waiting leaves that message unchanged and clears the count.
- R10: When a write and a due refresh land in the same cycle, the write message wins (`msg_kind` 0, the written byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Ownership trace enable |
| period_en | input | 1 | Periodic refresh enable |
| pid_we | input | 1 | Process-ID register write strobe |
| pid_wdata | input | 8 | Byte written to the process-ID register |
| sent_pulse | input | 1 | One-cycle pulse per message sent by the trace system |
| msg_valid | output | 1 | Ownership message waiting for the arbiter |
| msg_ack | input | 1 | Arbiter takes the message this cycle |
| msg_pid | output | 8 | Process ID carried by the message |
| msg_kind | output | 1 | 0 = write-triggered, 1 = periodic refresh |

## Verification
The checker tests every cycle that a write raises a write-coded message with the right byte, and that a waiting message stays stable until it is acknowledged. It also checks that a low enable empties the output, that no message appears without a write or pulse, and that periodic messages never start while refresh is off. The exact 256-pulse distance is counted only by the bench scenarios, and so are the count clearing on acknowledge, the absorbed refresh while a message waits, and write priority in a collision cycle. The same holds for tracking writes made while trace is disabled.

// File: rtl/pid_own_trace.sv
module pid_own_trace #(
  parameter int PID_W  = 8,
  parameter int PERIOD = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trace_en,
  input  logic             period_en,
  input  logic             pid_we,
  input  logic [PID_W-1:0] pid_wdata,
  input  logic             sent_pulse,
  output logic             msg_valid,
  input  logic             msg_ack,
  output logic [PID_W-1:0] msg_pid,
  output logic             msg_kind
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);
  localparam logic KIND_WR  = 1'b0;
  localparam logic KIND_PER = 1'b1;

  logic [PID_W-1:0] cur_pid;
  logic [CW-1:0]    cnt;
  logic             counting, due, accept, wr_evt;

  assign counting = trace_en && period_en;
  assign due      = counting && sent_pulse && (cnt == LAST);
  assign accept   = msg_valid && msg_ack;
  assign wr_evt   = trace_en && pid_we;

  always_ff @(posedge clk) begin
    if (!rst_n) cur_pid <= '0;
    else if (pid_we) cur_pid <= pid_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !counting || due || accept) cnt <= '0;
    else if (sent_pulse) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_pid   <= '0;
      msg_kind  <= KIND_WR;
    end else if (!trace_en) begin
      msg_valid <= 1'b0;
    end else if (wr_evt) begin
      msg_valid <= 1'b1;
      msg_pid   <= pid_wdata;
      msg_kind  <= KIND_WR;
    end else if (due && (!msg_valid || accept)) begin
      msg_valid <= 1'b1;
      msg_pid   <= cur_pid;
      msg_kind  <= KIND_PER;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pid_own_trace_chk.sv
module pid_own_trace_chk #(
  parameter int PID_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trace_en,
  input logic             period_en,
  input logic             pid_we,
  input logic [PID_W-1:0] pid_wdata,
  input logic             sent_pulse,
  input logic             msg_valid,
  input logic             msg_ack,
  input logic [PID_W-1:0] msg_pid,
  input logic             msg_kind
);
  // R2
  write_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && pid_we) |=> (msg_valid && msg_pid == $past(pid_wdata) && !msg_kind));

  // R3
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ack && trace_en && !pid_we)
      |=> (msg_valid && $stable(msg_pid) && $stable(msg_kind)));

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_en |=> !msg_valid);

  // R8
  no_periodic_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && !period_en) |=> (!msg_valid || !msg_kind));

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && !pid_we && !sent_pulse) |=> !msg_valid);
endmodule

bind pid_own_trace pid_own_trace_chk #(.PID_W(PID_W)) chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .period_en(period_en),
  .pid_we(pid_we), .pid_wdata(pid_wdata), .sent_pulse(sent_pulse),
  .msg_valid(msg_valid), .msg_ack(msg_ack), .msg_pid(msg_pid), .msg_kind(msg_kind)
);

// File: tb/pid_own_trace_test.sv
module pid_own_trace_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trace_en = 1'b0, period_en = 1'b0, pid_we = 1'b0;
  logic [7:0] pid_wdata = '0;
  logic       sent_pulse = 1'b0, msg_ack = 1'b0;
  logic       msg_valid, msg_kind;
  logic [7:0] msg_pid;

  int compared = 0, mismatched = 0;
  logic [8:0] expq[$];
  bit outstanding = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pid_own_trace uut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .period_en(period_en),
    .pid_we(pid_we), .pid_wdata(pid_wdata), .sent_pulse(sent_pulse),
    .msg_valid(msg_valid), .msg_ack(msg_ack), .msg_pid(msg_pid), .msg_kind(msg_kind)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_msg(input logic kind, input logic [7:0] pid);
    if (outstanding && expq.size() > 0) expq[expq.size()-1] = {kind, pid};
    else expq.push_back({kind, pid});
    outstanding = 1;
  endtask

  task automatic write_pid(input logic [7:0] d);
    pid_we = 1'b1; pid_wdata = d;
    if (trace_en) expect_msg(1'b0, d);
    step();
    pid_we = 1'b0;
  endtask

  task automatic pulses(input int n);
    sent_pulse = 1'b1;
    repeat (n) step();
    sent_pulse = 1'b0;
  endtask

  task automatic ack_once();
    msg_ack = 1'b1; step(); msg_ack = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ack) begin
      if (expq.size() == 0) check(1'b0, "R3 unexpected message", {7'd0, msg_kind, msg_pid}, 16'hFFFF);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        outstanding = 0;
        check({msg_kind, msg_pid} == e, "R2/R5/R6 message content",
              {7'd0, msg_kind, msg_pid}, {7'd0, e});
      end
    end
  end

  initial begin
    repeat (3) step();
    check(!msg_valid && msg_pid == 0 && !msg_kind, "R1 reset state",
          {7'd0, msg_valid, msg_pid}, 16'h0);
    rst_n = 1'b1;
    trace_en = 1'b1;
    step();

    write_pid(8'h3C);
    check(msg_valid && msg_pid == 8'h3C && !msg_kind, "R2 write message",
          {7'd0, msg_kind, msg_pid}, 16'h003C);
    repeat (3) step();
    check(msg_valid && msg_pid == 8'h3C && !msg_kind, "R3 held without ack",
          {7'd0, msg_valid, msg_pid}, 16'h013C);
    write_pid(8'h5A);
    check(msg_valid && msg_pid == 8'h5A && !msg_kind, "R5 replaced pending",
          {7'd0, msg_kind, msg_pid}, 16'h005A);
    ack_once();
    check(!msg_valid, "R3 drop after ack", {15'd0, msg_valid}, 16'h0);

    write_pid(8'h22);
    trace_en = 1'b0; step();
    expq.delete(); outstanding = 0;
    check(!msg_valid, "R4 withdrawn on disable", {15'd0, msg_valid}, 16'h0);
    write_pid(8'h77);
    step();
    check(!msg_valid, "R4 no message while disabled", {15'd0, msg_valid}, 16'h0);

    trace_en = 1'b1; period_en = 1'b1; step();
    pulses(255);
    check(!msg_valid, "R6 no refresh before 256", {15'd0, msg_valid}, 16'h0);
    expect_msg(1'b1, 8'h77);
    pulses(1);
    check(msg_valid && msg_kind && msg_pid == 8'h77, "R6 periodic refresh",
          {7'd0, msg_kind, msg_pid}, 16'h0177);
    ack_once();

    pulses(100);
    write_pid(8'h40);
    ack_once();
    pulses(200);
    check(!msg_valid, "R7 count cleared on ack", {15'd0, msg_valid}, 16'h0);
    expect_msg(1'b1, 8'h40);
    pulses(56);
    check(msg_valid && msg_kind && msg_pid == 8'h40, "R7 refresh after full count",
          {7'd0, msg_kind, msg_pid}, 16'h0140);
    ack_once();

    write_pid(8'h90);
    pulses(256);
    check(msg_valid && !msg_kind && msg_pid == 8'h90, "R9 pending kept on due refresh",
          {7'd0, msg_kind, msg_pid}, 16'h0090);
    ack_once();
    pulses(255);
    check(!msg_valid, "R9 count restarted", {15'd0, msg_valid}, 16'h0);
    expect_msg(1'b1, 8'h90);
    pulses(1);
    check(msg_valid && msg_kind && msg_pid == 8'h90, "R9 next refresh",
          {7'd0, msg_kind, msg_pid}, 16'h0190);
    ack_once();

    pulses(255);
    sent_pulse = 1'b1;
    write_pid(8'hA5);
    sent_pulse = 1'b0;
    check(msg_valid && !msg_kind && msg_pid == 8'hA5, "R10 write wins collision",
          {7'd0, msg_kind, msg_pid}, 16'h00A5);
    ack_once();

    period_en = 1'b0; step();
    pulses(300);
    check(!msg_valid, "R8 no refresh when off", {15'd0, msg_valid}, 16'h0);
    step();
    check(expq.size() == 0, "R3 all messages seen", 16'(expq.size()), 16'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 16'h0, 16'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule